// File: doc/BRIEF.md
# Two-Backplane Half-Bias LCD Frame Generator

This block turns a slow multiplex clock into the drive pattern for a liquid-crystal panel that has two backplanes and a half-supply bias. A two-bit divider steps on each falling edge of the multiplex clock. Its low bit is a phase signal that runs at half the multiplex rate. Its high bit is an inversion signal that runs at a quarter of the rate. The multiplex clock is an asynchronous input. It is synchronised into the system clock domain, and only its falling edges advance the divider.

Every segment holds a pair of stored bits. In each phase the segment output takes one bit of the pair and XORs it with the inversion signal. The two backplane outputs are 2-bit codes that name one of three voltage levels. In each phase one backplane is active and the other sits at mid level, and the roles swap with the phase. The active backplane sits at supply or at ground depending on the inversion signal. As a result, a lit segment sees the full voltage across the pixel and the average voltage is zero. After reset every output stays at zero until the first falling edge of the multiplex clock.

Top module: `lcd_duplex_framer`

## Requirements
- R1: `phase_o` starts at 0 and toggles once for every falling edge of `mux_clk`, so it runs at half the `mux_clk` rate.
- R2: `invert_o` starts at 0 and toggles on every second falling edge of `mux_clk` (each time `phase_o` returns from 1 to 0), so it runs at a quarter of the rate.
- R3: Segment n has its first stored bit at `seg_bits[2n]` and its second at `seg_bits[2n+1]`. Once started, `seg_out[n]` takes the first bit while `phase_o`=0 and the second bit while `phase_o`=1.
- R4: While `invert_o`=1 the selected bit is driven inverted on `seg_out[n]`; while `invert_o`=0 it passes unchanged.
- R5: Level codes: 2'b00 = ground, 2'b01 = mid (half supply), 2'b10 = supply; 2'b11 never appears. Once started, `bp1_lvl` is the active backplane and `bp2_lvl` is mid while `phase_o`=0, and the roles swap while `phase_o`=1.
- R6: The active backplane is at supply (2'b10) while `invert_o`=0 and at ground (2'b00) while `invert_o`=1.
- R7: After reset, `phase_o`, `invert_o`, all of `seg_out`, `bp1_lvl` and `bp2_lvl` are 0 until the first falling edge of `mux_clk`. Rising edges of `mux_clk` never change the outputs.
- R8: While `rst` is high, falling edges of `mux_clk` are blocked and the divider stays cleared. After `rst` is released, the outputs stay at zero until the next falling edge, and the sequence then restarts from its first step.
- R9: The effect of a falling edge of `mux_clk` appears on the outputs after at most three rising edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset; also blocks the multiplex clock |
| mux_clk | input | 1 | Asynchronous multiplex clock; its falling edges step the frame |
| seg_bits | input | 2*SEGS | Stored bit pair for each segment (first bit at 2n, second at 2n+1) |
| seg_out | output | SEGS | Segment drive bits after selection and inversion |
| bp1_lvl | output | 2 | Level code for backplane 1 |
| bp2_lvl | output | 2 | Level code for backplane 2 |
| phase_o | output | 1 | Phase signal, half the multiplex rate |
| invert_o | output | 1 | Inversion signal, quarter of the multiplex rate |

## Verification
The hardest situation to bring about is a falling edge of the multiplex clock that arrives while reset is held. The divider must ignore it, and after release the block must still show zeros rather than resume part-way through the sequence. The bench drives several falling edges during a reset in the middle of the run. It checks the outputs both during reset and after release, and only then steps the clock again to confirm that the sequence restarts from phase 0 with no inversion. The rest of the stimulus uses random 280-bit patterns over several full inversion periods. Every segment and both backplanes are compared with a bench model after each edge.

// File: rtl/lcd_duplex_framer.sv
module lcd_duplex_framer #(
  parameter int SEGS = 140,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mux_clk,
  input  logic [2*SEGS-1:0] seg_bits,
  output logic [SEGS-1:0]   seg_out,
  output logic [1:0]        bp1_lvl,
  output logic [1:0]        bp2_lvl,
  output logic              phase_o,
  output logic              invert_o
);
  localparam logic [1:0] LVL_GND = 2'b00;
  localparam logic [1:0] LVL_MID = 2'b01;
  localparam logic [1:0] LVL_SUP = 2'b10;

  logic [SYNC:0] mclk_q;
  logic          fall;
  logic [1:0]    div_q;
  logic          run_q;
  logic [1:0]    act_lvl;

  always_ff @(posedge clk) begin
    if (rst) mclk_q <= '0;
    else     mclk_q <= {mclk_q[SYNC-1:0], mux_clk};
  end

  assign fall = mclk_q[SYNC] & ~mclk_q[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= 2'b00;
      run_q <= 1'b0;
    end else if (fall) begin
      div_q <= div_q + 2'd1;
      run_q <= 1'b1;
    end
  end

  assign phase_o  = div_q[0];
  assign invert_o = div_q[1];

  genvar n;
  generate
    for (n = 0; n < SEGS; n++) begin : g_seg
      assign seg_out[n] = run_q & ((phase_o ? seg_bits[2*n+1] : seg_bits[2*n]) ^ invert_o);
    end
  endgenerate

  assign act_lvl = invert_o ? LVL_GND : LVL_SUP;
  assign bp1_lvl = !run_q ? LVL_GND : (phase_o ? LVL_MID : act_lvl);
  assign bp2_lvl = !run_q ? LVL_GND : (phase_o ? act_lvl : LVL_MID);

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> phase_o != $past(phase_o));

  // R2
  invert_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fall && phase_o) |=> invert_o != $past(invert_o));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(phase_o) && $stable(invert_o));

  // R5
  one_mid_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> ((bp1_lvl == LVL_MID) != (bp2_lvl == LVL_MID)) && bp1_lvl != 2'b11 && bp2_lvl != 2'b11);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (seg_out == '0 && bp1_lvl == LVL_GND && bp2_lvl == LVL_GND && !phase_o && !invert_o));

  // R8
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!phase_o && !invert_o && !run_q));
endmodule

// File: tb/sim_lcd_duplex_framer.sv
`timescale 1ns/1ps
module sim_lcd_duplex_framer;
  localparam int SEGS = 140;
  localparam int W = 2*SEGS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mux_clk = 1'b1;
  logic [W-1:0] seg_bits = '0;
  logic [SEGS-1:0] seg_out;
  logic [1:0] bp1_lvl, bp2_lvl;
  logic phase_o, invert_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_cnt = 0;
  bit m_run = 0;

  lcd_duplex_framer #(.SEGS(SEGS)) u0 (
    .clk(clk), .rst(rst), .mux_clk(mux_clk), .seg_bits(seg_bits),
    .seg_out(seg_out), .bp1_lvl(bp1_lvl), .bp2_lvl(bp2_lvl),
    .phase_o(phase_o), .invert_o(invert_o)
  );

  always #4 clk = ~clk;

  function automatic logic [SEGS-1:0] exp_seg(input logic [W-1:0] b, input int cnt, input bit run);
    logic [SEGS-1:0] r;
    bit ph, iv;
    ph = cnt[0];
    iv = cnt[1];
    for (int i = 0; i < SEGS; i++) r[i] = run ? ((ph ? b[2*i+1] : b[2*i]) ^ iv) : 1'b0;
    return r;
  endfunction

  function automatic logic [1:0] exp_bp(input int which, input int cnt, input bit run);
    bit ph, iv;
    ph = cnt[0];
    iv = cnt[1];
    if (!run) return 2'b00;
    if ((which == 1) == !ph) return iv ? 2'b00 : 2'b10;
    return 2'b01;
  endfunction

  task automatic check_all(input string tag);
    checks++;
    if (phase_o !== m_cnt[0] || invert_o !== m_cnt[1]) begin
      errors++;
      $display("FAIL %s R1/R2 phase/invert: got %b%b expected %b%b", tag, invert_o, phase_o, m_cnt[1], m_cnt[0]);
    end
    checks++;
    if (seg_out !== exp_seg(seg_bits, m_cnt, m_run)) begin
      errors++;
      $display("FAIL %s R3/R4 seg_out: got %h expected %h", tag, seg_out, exp_seg(seg_bits, m_cnt, m_run));
    end
    checks++;
    if (bp1_lvl !== exp_bp(1, m_cnt, m_run) || bp2_lvl !== exp_bp(2, m_cnt, m_run)) begin
      errors++;
      $display("FAIL %s R5/R6 backplanes: got %b/%b expected %b/%b", tag, bp1_lvl, bp2_lvl,
               exp_bp(1, m_cnt, m_run), exp_bp(2, m_cnt, m_run));
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic mfall(input string tag);
    @(negedge clk) mux_clk = 1'b0;
    // R9: effect visible after three rising edges
    settle(3);
    if (!rst) begin
      m_cnt = (m_cnt + 1) % 4;
      m_run = 1;
    end
    check_all(tag);
  endtask

  task automatic mrise(input string tag);
    @(negedge clk) mux_clk = 1'b1;
    settle(4);
    check_all(tag);
  endtask

  task automatic new_bits();
    for (int k = 0; k < W; k += 32) seg_bits[k +: 32] = W - k >= 32 ? $urandom() : $urandom() & ((1 << (W - k)) - 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    settle(3);
    check_all("reset R7");
    @(negedge clk) rst = 1'b0;
    settle(2);
    check_all("post-reset R7");
    new_bits();
    settle(1);
    check_all("idle with data R7");
    mrise("rise ignored R7");
    mfall("first fall R1 r3_");
    mrise("rise R7");
    // directed: all ones, all zeros
    seg_bits = '1;
    for (int c = 0; c < 4; c++) begin mfall("ones R4"); mrise("ones R7"); end
    seg_bits = '0;
    for (int c = 0; c < 4; c++) begin mfall("zeros R4"); mrise("zeros R7"); end
    // directed: first bits one, second bits zero
    for (int i = 0; i < SEGS; i++) seg_bits[2*i +: 2] = 2'b01;
    for (int c = 0; c < 4; c++) begin mfall("pair R3"); mrise("pair R6"); end
    // random over several inversion periods
    for (int c = 0; c < 40; c++) begin
      new_bits();
      settle(1);
      check_all("random data R3");
      mfall("random R2");
      mrise("random R5");
    end
    // reset in the middle of the run with falling edges during reset (R8)
    @(negedge clk) rst = 1'b1;
    m_cnt = 0;
    m_run = 0;
    settle(2);
    check_all("in reset R8");
    for (int c = 0; c < 3; c++) begin mrise("blocked R8"); mfall("blocked R8"); end
    mrise("blocked R8");
    @(negedge clk) rst = 1'b0;
    settle(4);
    check_all("after release R8");
    new_bits();
    for (int c = 0; c < 8; c++) begin mfall("restart R8"); mrise("restart R1"); end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule